// File: doc/BRIEF.md
# Dual Two-Phase Timer with Watchdog Mode

The block holds two independent programmable timers behind a small word-addressed register bus. Each timer, once enabled, repeats a period made of two down-counted phases: a first phase whose length comes from the timer's timeout count register, then a second phase whose length comes from its pulse count register. A square-wave output for each timer is low during the first phase and high during the second. Equal values in both registers give a 50% duty cycle. Timer 1 also gives an interrupt pulse at the end of every period.

Timer 0 can instead act as a watchdog. When it is enabled while the low byte of its timeout register holds the code 0xFF, it counts down its pulse count register once. It then raises a reset request for a number of cycles taken from bits 31:8 of the timeout register, and stays quiet until software clears and sets its enable bit again. To reprogram a timer, software clears its enable bit, writes its count registers and sets the bit again. Setting the bit restarts the timer from the first phase with the current register contents.

Top module: `dual_phase_timer`

## Requirements
- R1: After reset both enable bits are 0, every register reads 0, and tmr0Sq, tmr1Sq, tmr1Irq and wdRstReq are low.
- R2: Registers are selected by busAddr[4:2]: 0 control, 1 timer 1 timeout count, 2 timer 0 timeout count, 3 timer 1 pulse count, 4 timer 0 pulse count. Each count register reads back the full 32-bit word last written. The control register keeps bits 1:0 and reads 0 above them.
- R3: A control write that sets a timer's enable bit (bit 0 for timer 0, bit 1 for timer 1) takes effect at that clock edge. From the next edge the timer spends T cycles with its square output low, then P cycles with it high, and repeats. T is the timeout count and P is the pulse count.
- R4: tmr1Irq is high for exactly one cycle, the cycle right after each timer 1 pulse phase ends.
- R5: A count of 0 is treated as 1, so the shortest period is 2 cycles.
- R6: A control write that clears a timer's enable bit returns that timer to idle at the next edge: its square output is low and no interrupt or reset request follows. Setting the bit again restarts from the timeout phase using the register values written while the timer was off.
- R7: The two timers run independently. Timer 0 in plain mode behaves as in R3 on tmr0Sq.
- R8: If timer 0 starts with bits 7:0 of its timeout register equal to 0xFF, tmr0Sq stays low. It counts W cycles, where W is its pulse count (0 read as 1). wdRstReq is then high for D cycles, where D is timeout bits 31:8 (0 read as 1). After that wdRstReq stays low.
- R9: Clearing and then setting enable bit 0 in watchdog mode restarts the full W-cycle count. This applies both before and after the reset request has fired.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 5 | Byte address; bits 4:2 select the register |
| busWrEn | input | 1 | Write strobe, one cycle per write |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |
| tmr0Sq | output | 1 | Timer 0 square output, high in the pulse phase |
| tmr1Sq | output | 1 | Timer 1 square output, high in the pulse phase |
| tmr1Irq | output | 1 | One-cycle pulse at the end of each timer 1 period |
| wdRstReq | output | 1 | Watchdog reset request from timer 0 |

## Verification
The assertions assume that a write lasts exactly one clock cycle and that busAddr and busWrData are steady while busWrEn is high. The checks on disabling take the control write itself as the trigger, so they only hold if no further enable write lands in the cycle that follows. The stimulus drives every input at the falling edge and holds it for a whole cycle. It leaves an idle cycle between writes and only changes count registers while their timer is disabled. Because zero counts are raised to one, the interrupt properties hold for any value the bench writes.

// File: rtl/dpt_pkg.sv
package dpt_pkg;

  localparam int NUM_TMR = 2;

  // word index of each register (busAddr[4:2])
  localparam int REG_CTRL = 0;
  localparam int REG_TC1  = 1;
  localparam int REG_TC0  = 2;
  localparam int REG_PD1  = 3;
  localparam int REG_PD0  = 4;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_TMO,
    PH_PLS,
    PH_WDCNT,
    PH_WDRST,
    PH_WDDONE
  } phase_e;

  typedef enum logic [1:0] {
    SEL_TMO,
    SEL_PLS,
    SEL_DUR
  } load_sel_e;

  typedef struct packed {
    logic      load;
    load_sel_e sel;
    logic      dec;
  } cnt_strobe_t;

endpackage

// File: rtl/dpt_datapath.sv
module dpt_datapath
  import dpt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] WD_CODE = '1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [ADDR_W-1:0]           busAddr,
  input  logic                        busWrEn,
  input  logic [DATA_W-1:0]           busWrData,
  output logic [DATA_W-1:0]           busRdData,
  input  cnt_strobe_t [NUM_TMR-1:0]   strobe,
  output logic [NUM_TMR-1:0]          cntZero,
  output logic [NUM_TMR-1:0]          enable,
  output logic [NUM_TMR-1:0]          wdCode
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0]   regIdx;
  logic [NUM_TMR-1:0] ctrlReg;
  logic [DATA_W-1:0]  tcReg [NUM_TMR];
  logic [DATA_W-1:0]  pdReg [NUM_TMR];
  logic [1:0]         unusedByteSel;

  assign regIdx        = busAddr[ADDR_W-1:2];
  assign unusedByteSel = busAddr[1:0];
  assign enable        = ctrlReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
      for (int i = 0; i < NUM_TMR; i++) begin
        tcReg[i] <= '0;
        pdReg[i] <= '0;
      end
    end else if (busWrEn) begin
      case (int'(regIdx))
        REG_CTRL: ctrlReg  <= busWrData[NUM_TMR-1:0];
        REG_TC1:  tcReg[1] <= busWrData;
        REG_TC0:  tcReg[0] <= busWrData;
        REG_PD1:  pdReg[1] <= busWrData;
        REG_PD0:  pdReg[0] <= busWrData;
        default: ;
      endcase
    end
  end

  always_comb begin
    busRdData = '0;
    case (int'(regIdx))
      REG_CTRL: busRdData[NUM_TMR-1:0] = ctrlReg;
      REG_TC1:  busRdData = tcReg[1];
      REG_TC0:  busRdData = tcReg[0];
      REG_PD1:  busRdData = pdReg[1];
      REG_PD0:  busRdData = pdReg[0];
      default:  busRdData = '0;
    endcase
  end

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_cnt
    logic [DATA_W-1:0] loadVal;
    logic [DATA_W-1:0] cnt;

    always_comb begin
      case (strobe[i].sel)
        SEL_TMO: loadVal = tcReg[i];
        SEL_PLS: loadVal = pdReg[i];
        default: loadVal = DATA_W'(tcReg[i][DATA_W-1:CODE_W]);
      endcase
    end

    // a phase of length N holds N-1 .. 0; zero is raised to one
    always_ff @(posedge clk) begin
      if (!rstN) begin
        cnt <= '0;
      end else if (strobe[i].load) begin
        cnt <= (loadVal == '0) ? '0 : loadVal - 1'b1;
      end else if (strobe[i].dec) begin
        cnt <= cnt - 1'b1;
      end
    end

    assign cntZero[i] = (cnt == '0);
    assign wdCode[i]  = (tcReg[i][CODE_W-1:0] == WD_CODE);
  end

endmodule

// File: rtl/dpt_control.sv
module dpt_control
  import dpt_pkg::*;
#(
  parameter bit HAS_WDOG = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        wdCode,
  input  logic        cntZero,
  output cnt_strobe_t strobe,
  output logic        sqOut,
  output logic        irqOut,
  output logic        rstOut
);

  phase_e phase;
  phase_e phaseNext;
  logic   doneNext;

  always_comb begin
    strobe    = '{load: 1'b0, sel: SEL_TMO, dec: 1'b0};
    phaseNext = phase;
    doneNext  = 1'b0;
    if (!enable) begin
      phaseNext = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE: begin
          strobe.load = 1'b1;
          if (HAS_WDOG && wdCode) begin
            phaseNext  = PH_WDCNT;
            strobe.sel = SEL_PLS;
          end else begin
            phaseNext  = PH_TMO;
            strobe.sel = SEL_TMO;
          end
        end
        PH_TMO: begin
          if (cntZero) begin
            phaseNext   = PH_PLS;
            strobe.load = 1'b1;
            strobe.sel  = SEL_PLS;
          end else begin
            strobe.dec = 1'b1;
          end
        end
        PH_PLS: begin
          if (cntZero) begin
            phaseNext   = PH_TMO;
            strobe.load = 1'b1;
            strobe.sel  = SEL_TMO;
            doneNext    = 1'b1;
          end else begin
            strobe.dec = 1'b1;
          end
        end
        PH_WDCNT: begin
          if (cntZero) begin
            phaseNext   = PH_WDRST;
            strobe.load = 1'b1;
            strobe.sel  = SEL_DUR;
          end else begin
            strobe.dec = 1'b1;
          end
        end
        PH_WDRST: begin
          if (cntZero) begin
            phaseNext = PH_WDDONE;
          end else begin
            strobe.dec = 1'b1;
          end
        end
        default: phaseNext = phase;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      irqOut <= 1'b0;
    end else begin
      phase  <= phaseNext;
      irqOut <= doneNext;
    end
  end

  assign sqOut  = (phase == PH_PLS);
  assign rstOut = (phase == PH_WDRST);

endmodule

// File: rtl/dual_phase_timer.sv
module dual_phase_timer
  import dpt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int CODE_W = 8,
  parameter logic [CODE_W-1:0] WD_CODE = '1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic              tmr0Sq,
  output logic              tmr1Sq,
  output logic              tmr1Irq,
  output logic              wdRstReq
);

  cnt_strobe_t [NUM_TMR-1:0] strobe;
  logic [NUM_TMR-1:0] cntZero;
  logic [NUM_TMR-1:0] enable;
  logic [NUM_TMR-1:0] wdCode;
  logic [NUM_TMR-1:0] sqVec;
  logic [NUM_TMR-1:0] irqVec;
  logic [NUM_TMR-1:0] rstVec;
  logic               unusedOuts;

  dpt_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CODE_W (CODE_W),
    .WD_CODE(WD_CODE)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .strobe   (strobe),
    .cntZero  (cntZero),
    .enable   (enable),
    .wdCode   (wdCode)
  );

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    dpt_control #(
      .HAS_WDOG(i == 0)
    ) u_ctrl (
      .clk    (clk),
      .rstN   (rstN),
      .enable (enable[i]),
      .wdCode (wdCode[i]),
      .cntZero(cntZero[i]),
      .strobe (strobe[i]),
      .sqOut  (sqVec[i]),
      .irqOut (irqVec[i]),
      .rstOut (rstVec[i])
    );
  end

  assign tmr0Sq     = sqVec[0];
  assign tmr1Sq     = sqVec[1];
  assign tmr1Irq    = irqVec[1];
  assign wdRstReq   = rstVec[0];
  assign unusedOuts = irqVec[0] ^ rstVec[1];

endmodule

// File: rtl/dpt_checker.sv
module dpt_checker (
  input logic        clk,
  input logic        rstN,
  input logic [4:0]  busAddr,
  input logic        busWrEn,
  input logic [31:0] busWrData,
  input logic        tmr0Sq,
  input logic        tmr1Sq,
  input logic        tmr1Irq,
  input logic        wdRstReq
);

  logic ctrlWrite;
  assign ctrlWrite = busWrEn && (busAddr[4:2] == 3'd0);

  // R4: interrupt lasts a single cycle
  a_r4_irq_single: assert property (@(posedge clk) disable iff (!rstN)
    tmr1Irq |=> !tmr1Irq);

  // R4: interrupt only directly after a pulse phase
  a_r4_irq_after_pulse: assert property (@(posedge clk) disable iff (!rstN)
    tmr1Irq |-> $past(tmr1Sq));

  // R6: clearing timer 1 enable silences it from the following cycle
  a_r6_t1_off_idle: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlWrite && !busWrData[1]) |=> (!tmr1Sq && !tmr1Irq));

  // R6, R9: clearing timer 0 enable drops its square and reset outputs
  a_r9_t0_off_idle: assert property (@(posedge clk) disable iff (!rstN)
    $past(ctrlWrite && !busWrData[0]) |=> (!tmr0Sq && !wdRstReq));

  // R8: watchdog request never coincides with a timer 0 square pulse
  a_r8_wd_no_sq: assert property (@(posedge clk) disable iff (!rstN)
    wdRstReq |-> !tmr0Sq);

endmodule

bind dual_phase_timer dpt_checker u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .busAddr  (busAddr),
  .busWrEn  (busWrEn),
  .busWrData(busWrData),
  .tmr0Sq   (tmr0Sq),
  .tmr1Sq   (tmr1Sq),
  .tmr1Irq  (tmr1Irq),
  .wdRstReq (wdRstReq)
);

// File: tb/dual_phase_timer_tb.sv
module dual_phase_timer_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [4:0]  busAddr = '0;
  logic        busWrEn = 1'b0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic        tmr0Sq, tmr1Sq, tmr1Irq, wdRstReq;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  dual_phase_timer u_dut (
    .clk      (clk),
    .rstN     (rstN),
    .busAddr  (busAddr),
    .busWrEn  (busWrEn),
    .busWrData(busWrData),
    .busRdData(busRdData),
    .tmr0Sq   (tmr0Sq),
    .tmr1Sq   (tmr1Sq),
    .tmr1Irq  (tmr1Irq),
    .wdRstReq (wdRstReq)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic busWrite(input int idx, input logic [31:0] data);
    @(negedge clk);
    busAddr   = 5'(idx * 4);
    busWrData = data;
    busWrEn   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input int idx, output logic [31:0] data);
    @(negedge clk);
    busAddr = 5'(idx * 4);
    #1;
    data = busRdData;
  endtask

  function automatic int eff(input int v);
    return (v == 0) ? 1 : v;
  endfunction

  function automatic bit expSq(input int tc, input int pd, input int t);
    int per;
    per = eff(tc) + eff(pd);
    return (t % per) >= eff(tc);
  endfunction

  function automatic bit expIrq(input int tc, input int pd, input int t);
    int per;
    per = eff(tc) + eff(pd);
    return (t > 0) && ((t % per) == 0);
  endfunction

  // clears control, loads the four count registers, then writes ctrlVal;
  // returns in the cycle right after the enabling edge
  task automatic startTimers(input logic [1:0] ctrlVal, input logic [31:0] tc0,
                             input logic [31:0] pd0, input logic [31:0] tc1,
                             input logic [31:0] pd1);
    busWrite(0, 32'h0);
    busWrite(2, tc0);
    busWrite(4, pd0);
    busWrite(1, tc1);
    busWrite(3, pd1);
    busWrite(0, {30'h0, ctrlVal});
  endtask

  // in watchdog mode a0 is the duration D and b0 the count W
  task automatic observe(input string req, input int n, input bit en0, input bit wd0,
                         input int a0, input int b0, input bit en1, input int tc1,
                         input int pd1);
    int bad = 0;
    int firstK = 0;
    logic [3:0] firstAct = '0;
    logic [3:0] firstExp = '0;
    for (int k = 0; k < n; k++) begin
      int t;
      logic [3:0] act;
      logic [3:0] exp;
      t = k - 1;
      exp = '0;
      if (k > 0) begin
        if (en0 && !wd0) exp[3] = expSq(a0, b0, t);
        if (en1) begin
          exp[2] = expSq(tc1, pd1, t);
          exp[1] = expIrq(tc1, pd1, t);
        end
        if (en0 && wd0) exp[0] = (t >= eff(b0)) && (t < eff(b0) + eff(a0));
      end
      act = {tmr0Sq, tmr1Sq, tmr1Irq, wdRstReq};
      if (act !== exp) begin
        if (bad == 0) begin
          firstK = k;
          firstAct = act;
          firstExp = exp;
        end
        bad++;
      end
      @(negedge clk);
    end
    check(bad == 0, req, $sformatf("outputs {sq0,sq1,irq1,rst} from cycle %0d", firstK),
          longint'(firstAct), longint'(firstExp));
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check({tmr0Sq, tmr1Sq, tmr1Irq, wdRstReq} == 4'b0, "R1", "outputs after reset",
          longint'({tmr0Sq, tmr1Sq, tmr1Irq, wdRstReq}), 0);
    for (int i = 0; i < 5; i++) begin
      busRead(i, d);
      check(d == 32'h0, "R1", $sformatf("register %0d after reset", i), d, 0);
    end
  endtask

  task automatic t_readback();
    logic [31:0] vals [5];
    logic [31:0] d;
    vals[0] = 32'hFFFF_FFFF;
    vals[1] = 32'h1234_5678;
    vals[2] = 32'h00AB_CD12;
    vals[3] = 32'hDEAD_BEEF;
    vals[4] = 32'h0F0F_0F0F;
    for (int i = 1; i < 5; i++) busWrite(i, vals[i]);
    busWrite(0, vals[0]);
    for (int i = 0; i < 5; i++) begin
      logic [31:0] e;
      busRead(i, d);
      e = (i == 0) ? 32'h3 : vals[i];
      check(d == e, "R2", $sformatf("readback of register %0d", i), d, e);
    end
    busWrite(0, 32'h0);
  endtask

  task automatic t_periodic();
    startTimers(2'b10, 0, 0, 3, 2);
    observe("R3", 20, 0, 0, 0, 0, 1, 3, 2);
    startTimers(2'b10, 0, 0, 1, 1);
    observe("R4", 12, 0, 0, 0, 0, 1, 1, 1);
    startTimers(2'b10, 0, 0, 5, 5);
    observe("R4", 30, 0, 0, 0, 0, 1, 5, 5);
  endtask

  task automatic t_zero_counts();
    startTimers(2'b10, 0, 0, 0, 0);
    observe("R5", 10, 0, 0, 0, 0, 1, 0, 0);
    startTimers(2'b10, 0, 0, 0, 4);
    observe("R5", 16, 0, 0, 0, 0, 1, 0, 4);
  endtask

  task automatic t_disable_restart();
    startTimers(2'b10, 0, 0, 2, 3);
    observe("R6", 9, 0, 0, 0, 0, 1, 2, 3);
    busWrite(0, 32'h0);
    @(negedge clk);
    observe("R6", 10, 0, 0, 0, 0, 0, 0, 0);
    busWrite(1, 32'd4);
    busWrite(3, 32'd1);
    busWrite(0, 32'h2);
    observe("R6", 16, 0, 0, 0, 0, 1, 4, 1);
    busWrite(0, 32'h0);
  endtask

  task automatic t_both();
    startTimers(2'b11, 2, 2, 3, 1);
    observe("R7", 24, 1, 0, 2, 2, 1, 3, 1);
    startTimers(2'b01, 1, 6, 0, 0);
    observe("R7", 16, 1, 0, 1, 6, 0, 0, 0);
  endtask

  task automatic t_watchdog();
    startTimers(2'b01, (32'd3 << 8) | 32'hFF, 5, 0, 0);
    observe("R8", 16, 1, 1, 3, 5, 0, 0, 0);
    busWrite(0, 32'h0);
    busWrite(0, 32'h1);
    observe("R9", 16, 1, 1, 3, 5, 0, 0, 0);
    startTimers(2'b01, 32'h0000_00FF, 0, 0, 0);
    observe("R8", 6, 1, 1, 0, 0, 0, 0, 0);
    startTimers(2'b01, (32'd2 << 8) | 32'hFF, 6, 0, 0);
    repeat (4) @(negedge clk);
    busWrite(0, 32'h0);
    busWrite(0, 32'h1);
    observe("R9", 14, 1, 1, 2, 6, 0, 0, 0);
    startTimers(2'b11, (32'd4 << 8) | 32'hFF, 3, 2, 2);
    observe("R8", 14, 1, 1, 4, 3, 1, 2, 2);
    busWrite(0, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    t_periodic();
    t_zero_counts();
    t_disable_restart();
    t_both();
    t_watchdog();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule